// File: doc/BRIEF.md
# Atomic Read-Modify-Write ALU

This unit computes the memory update for an atomic read-modify-write. A request carries the value that memory held before the operation, the operand from the register file, a 5-bit operation code and a width select. One clock after the request is accepted, the unit returns two results. The first is the value for the destination register, which is always the old memory value. The second is the value to write back to memory, together with an enable that qualifies it.

The unit supports nine operations:

- add
- swap
- the three bitwise logic operations
- signed minimum and maximum
- unsigned minimum and maximum

In word mode only the low half of each operand takes part. The register result is the low half of the old value, sign-extended to the full width. The unit accepts a new request in every cycle. An operation code outside the nine legal codes still produces a response, but the response is flagged illegal and carries no store.

Top module: `amo_alu`

## Requirements
- R1: `req_ready` is always 1. Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` high on the following clock, so back-to-back requests give back-to-back responses.
- R2: `rd_value` equals the old memory value when `dword`=1. When `dword`=0 it equals bits [31:0] of the old value with bit 31 copied into bits [63:32]. This holds for every code, including illegal ones.
- R3: Code 5'h00 stores the sum of the operand and the old value. In word mode the sum wraps at 32 bits.
- R4: Code 5'h01 stores the register operand unchanged.
- R5: Codes 5'h04, 5'h08 and 5'h0C store the bitwise XOR, OR and AND of the two inputs.
- R6: Codes 5'h10 and 5'h14 store the signed minimum and the signed maximum. In word mode the comparison uses bits [31:0] as two's-complement numbers.
- R7: Codes 5'h18 and 5'h1C store the unsigned minimum and the unsigned maximum, at the selected width.
- R8: In word mode bits [63:32] of `store_value` are 0.
- R9: Any other code sets `illegal_op`=1, `store_en`=0 and `store_value`=0 in its response cycle. For a legal code the response has `store_en`=1 and `illegal_op`=0.
- R10: Outside a response cycle, `store_en` and `illegal_op` are 0.
- R11: While reset is held, and after it until the first request, `rsp_valid`, `store_en`, `illegal_op`, `rd_value` and `store_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (constant 1) |
| op_code | input | 5 | Operation select |
| dword | input | 1 | 1 = full-width operation, 0 = low-half (word) operation |
| mem_old | input | XLEN | Value read from memory |
| reg_src | input | XLEN | Register operand |
| rsp_valid | output | 1 | Response cycle |
| rd_value | output | XLEN | Value for the destination register |
| store_value | output | XLEN | Value to write to memory |
| store_en | output | 1 | Memory write required |
| illegal_op | output | 1 | Code was not a legal operation |

## Verification
Two behaviours can fall in the same cycle. One is the response to one request; the other is the capture of the next request, which may use a different code or width. The bench provokes this with back-to-back requests: an illegal code followed directly by a legal word-mode minimum, and the reverse order. In each response cycle it checks that `store_en` and `illegal_op` belong to the request that produced that response. It also checks that `rd_value` still carries the sign-extended old value of that request, with no flag or data carried over from its neighbour.

// File: rtl/amo_alu.sv
module amo_alu #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [4:0]      op_code,
  input  logic            dword,
  input  logic [XLEN-1:0] mem_old,
  input  logic [XLEN-1:0] reg_src,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rd_value,
  output logic [XLEN-1:0] store_value,
  output logic            store_en,
  output logic            illegal_op
);
  localparam int HALF = XLEN / 2;

  logic            accept, legal, cmp_signed, src_lt_old;
  logic [XLEN:0]   cmp_old, cmp_src;
  logic [XLEN-1:0] result, rd_next, store_next;

  assign req_ready  = 1'b1;
  assign accept     = req_valid & req_ready;
  assign cmp_signed = ~op_code[3];

  always_comb begin
    if (dword) begin
      cmp_old = {cmp_signed & mem_old[XLEN-1], mem_old};
      cmp_src = {cmp_signed & reg_src[XLEN-1], reg_src};
    end else begin
      cmp_old = {{(XLEN-HALF+1){cmp_signed & mem_old[HALF-1]}}, mem_old[HALF-1:0]};
      cmp_src = {{(XLEN-HALF+1){cmp_signed & reg_src[HALF-1]}}, reg_src[HALF-1:0]};
    end
  end

  assign src_lt_old = $signed(cmp_src) < $signed(cmp_old);

  always_comb begin
    legal  = 1'b1;
    result = '0;
    case (op_code)
      5'h00: result = reg_src + mem_old;
      5'h01: result = reg_src;
      5'h04: result = reg_src ^ mem_old;
      5'h08: result = reg_src | mem_old;
      5'h0C: result = reg_src & mem_old;
      5'h10, 5'h18: result = src_lt_old ? reg_src : mem_old;
      5'h14, 5'h1C: result = src_lt_old ? mem_old : reg_src;
      default: legal = 1'b0;
    endcase
  end

  assign rd_next    = dword ? mem_old : {{HALF{mem_old[HALF-1]}}, mem_old[HALF-1:0]};
  assign store_next = !legal ? '0 : dword ? result : {{HALF{1'b0}}, result[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      store_en    <= 1'b0;
      illegal_op  <= 1'b0;
      rd_value    <= '0;
      store_value <= '0;
    end else begin
      rsp_valid  <= accept;
      store_en   <= accept & legal;
      illegal_op <= accept & ~legal;
      if (accept) begin
        rd_value    <= rd_next;
        store_value <= store_next;
      end
    end
  end
endmodule

// File: rtl/amo_alu_chk.sv
module amo_alu_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [4:0]      op_code,
  input logic            dword,
  input logic [XLEN-1:0] mem_old,
  input logic [XLEN-1:0] reg_src,
  input logic            rsp_valid,
  input logic [XLEN-1:0] rd_value,
  input logic [XLEN-1:0] store_value,
  input logic            store_en,
  input logic            illegal_op
);
  localparam int HALF = XLEN / 2;

  logic code_ok;
  assign code_ok = op_code inside {5'h00, 5'h01, 5'h04, 5'h08, 5'h0C,
                                   5'h10, 5'h14, 5'h18, 5'h1C};

  assert_always_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready);
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_rd_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dword) |=> rd_value == $past(mem_old));
  assert_rd_word_sext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dword) |=> rd_value[XLEN-1:HALF] == {HALF{rd_value[HALF-1]}});
  assert_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dword && op_code == 5'h01) |=> store_value == $past(reg_src));
  assert_word_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !dword) |=> store_value[XLEN-1:HALF] == '0);
  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !code_ok) |=> illegal_op && !store_en && store_value == '0);
  assert_legal_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && code_ok) |=> store_en && !illegal_op);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!store_en && !illegal_op));
endmodule

bind amo_alu amo_alu_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/amo_alu_tb_top.sv
`timescale 1ns/1ps
module amo_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  op_code = '0;
  logic        dword = 1'b0;
  logic [63:0] mem_old = '0, reg_src = '0;
  logic        rsp_valid, store_en, illegal_op;
  logic [63:0] rd_value, store_value;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  amo_alu dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_code(op_code), .dword(dword), .mem_old(mem_old), .reg_src(reg_src),
    .rsp_valid(rsp_valid), .rd_value(rd_value), .store_value(store_value),
    .store_en(store_en), .illegal_op(illegal_op));

  function automatic logic [63:0] exp_rd(logic dw, logic [63:0] o);
    return dw ? o : {{32{o[31]}}, o[31:0]};
  endfunction

  function automatic bit is_legal(logic [4:0] op);
    return op inside {5'h00, 5'h01, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
  endfunction

  function automatic logic [63:0] exp_store(logic [4:0] op, logic dw, logic [63:0] o, logic [63:0] s);
    logic [63:0] r;
    bit slt, ult;
    if (dw) begin
      slt = $signed(s) < $signed(o);
      ult = s < o;
    end else begin
      slt = $signed(s[31:0]) < $signed(o[31:0]);
      ult = s[31:0] < o[31:0];
    end
    case (op)
      5'h00: r = s + o;
      5'h01: r = s;
      5'h04: r = s ^ o;
      5'h08: r = s | o;
      5'h0C: r = s & o;
      5'h10: r = slt ? s : o;
      5'h14: r = slt ? o : s;
      5'h18: r = ult ? s : o;
      5'h1C: r = ult ? o : s;
      default: r = '0;
    endcase
    if (!dw) r = {32'h0, r[31:0]};
    return r;
  endfunction

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] op, logic dw, logic [63:0] o, logic [63:0] s);
    req_valid = 1'b1; op_code = op; dword = dw; mem_old = o; reg_src = s;
  endtask

  task automatic judge(string req, logic [4:0] op, logic dw, logic [63:0] o, logic [63:0] s);
    check64("R1", {req, " rsp_valid"}, {63'h0, rsp_valid}, 64'h1);
    check64("R2", {req, " rd_value"}, rd_value, exp_rd(dw, o));
    check64(req, "store_value", store_value, exp_store(op, dw, o, s));
    check64("R9", {req, " store_en"}, {63'h0, store_en}, {63'h0, is_legal(op)});
    check64("R9", {req, " illegal_op"}, {63'h0, illegal_op}, {63'h0, !is_legal(op)});
  endtask

  task automatic single(string req, logic [4:0] op, logic dw, logic [63:0] o, logic [63:0] s);
    @(negedge clk); drive(op, dw, o, s);
    @(negedge clk); req_valid = 1'b0;
    judge(req, op, dw, o, s);
    @(negedge clk);
    check64("R1", "rsp_valid one cycle", {63'h0, rsp_valid}, 64'h0);
    check64("R10", "idle flags", {62'h0, store_en, illegal_op}, 64'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check64("R11", "reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
    check64("R11", "reset flags", {62'h0, store_en, illegal_op}, 64'h0);
    check64("R11", "reset rd_value", rd_value, 64'h0);
    check64("R11", "reset store_value", store_value, 64'h0);
    check64("R1", "ready", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_arith();
    single("R3", 5'h00, 1'b1, 64'h0000_0001_FFFF_FFFF, 64'h1);
    single("R3", 5'h00, 1'b0, 64'h0000_0001_FFFF_FFFF, 64'h1);
    single("R4", 5'h01, 1'b1, 64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0BAD_F00D);
    single("R4", 5'h01, 1'b0, 64'h0000_0000_8000_0000, 64'hDEAD_BEEF_0BAD_F00D);
  endtask

  task automatic t_logic();
    single("R5", 5'h04, 1'b1, 64'hF0F0_F0F0_AAAA_5555, 64'hFF00_FF00_0F0F_F0F0);
    single("R5", 5'h08, 1'b1, 64'hF0F0_F0F0_AAAA_5555, 64'hFF00_FF00_0F0F_F0F0);
    single("R5", 5'h0C, 1'b0, 64'hF0F0_F0F0_AAAA_5555, 64'hFF00_FF00_0F0F_F0F0);
  endtask

  task automatic t_minmax();
    single("R6", 5'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h3);
    single("R6", 5'h14, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h3);
    single("R7", 5'h18, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h3);
    single("R7", 5'h1C, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'h3);
    single("R6", 5'h10, 1'b0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001);
    single("R6", 5'h10, 1'b1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001);
    single("R7", 5'h1C, 1'b0, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001);
    single("R8", 5'h14, 1'b0, 64'h1234_5678_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_illegal();
    single("R9", 5'h02, 1'b1, 64'h5, 64'h6);
    single("R9", 5'h1F, 1'b0, 64'h8000_0000, 64'h6);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); drive(5'h03, 1'b0, 64'h0000_0000_FFFF_FFF0, 64'h1);
    @(negedge clk);
    judge("R9", 5'h03, 1'b0, 64'h0000_0000_FFFF_FFF0, 64'h1);
    drive(5'h10, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_0000);
    @(negedge clk);
    judge("R6", 5'h10, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_0000);
    drive(5'h0D, 1'b1, 64'h7, 64'h9);
    @(negedge clk); req_valid = 1'b0;
    judge("R9", 5'h0D, 1'b1, 64'h7, 64'h9);
    @(negedge clk);
    check64("R10", "idle after burst", {61'h0, rsp_valid, store_en, illegal_op}, 64'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check64("R11", "post-reset idle", {61'h0, rsp_valid, store_en, illegal_op}, 64'h0);
    t_arith();
    t_logic();
    t_minmax();
    t_illegal();
    t_back_to_back();
    finish_run();
  end

  initial begin
    #(200000 * 20);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule